// File: doc/BRIEF.md
# Radix-2 Decimation-in-Frequency Butterfly with Scaled Outputs

This block performs one radix-2 decimation-in-frequency butterfly per accepted input, as one building block of an N-point forward or inverse FFT. Each accepted input carries two complex samples `a` and `b`, the index `k` of the twiddle factor, and a direction bit. The block returns the halved sum `(a+b)/2` on its upper output. On its lower output it returns the halved difference `(a-b)/2`, rotated by the twiddle factor `W_k`. In the inverse direction it uses the conjugate of `W_k`.

The twiddle factors come from an on-chip ROM that the block fills when it is elaborated. Each twiddle component is held as a sign plus the positions of at most `NTERMS` one-bits. The rotation is therefore done by an iterative shift-and-add complex multiplier, which adds one shifted operand per cycle. These multipliers are not pipelined. Throughput instead comes from a set of `NUNITS` identical multipliers, and accepted butterflies are handed to them in strict rotation. Each multiplier also carries the matching sum, so both outputs leave together, in input order, after a fixed latency.

The ordering of butterflies across stages, and the addressing of the sample memory, belong to the surrounding logic.

Top module: `dif_bfly_r2`

## Requirements
- R1: The upper output equals `(a+b) >>> 1` for the real part and for the imaginary part separately. The sum is formed one bit wider than the data, so extreme inputs never wrap, and the result is truncated toward minus infinity.
- R2: Let `d = a-b`, formed one bit wider than the data. Let `Wr` and `Wi` be the signed twiddle integers, with 30 fractional bits. The lower output real part is `(dr*Wr - di*Wi) >>> 31`, and the lower output imaginary part is `(dr*Wi + di*Wr) >>> 31`. Each is taken as the low 32 bits.
- R3: For index `k`, the twiddle is `cos(2πk/N) - j·sin(2πk/N)`, with `N = NPTS`. Each component's magnitude is first rounded to the nearest multiple of 2^-30. Only its `NTERMS` most significant one-bits are then kept, and the lower one-bits are dropped. The sign of the component is applied afterwards.
- R4: With `in_inverse = 1`, the sign of the twiddle's imaginary part is flipped, which rotates by the conjugate. With `in_inverse = 0`, the forward twiddle of R3 is used.
- R5: An input accepted at clock edge `P` appears with `out_valid = 1` right after edge `P + 2*NTERMS + 2`. Outputs leave in the order in which their inputs were accepted.
- R6: With `NUNITS >= 2*NTERMS + 2`, `in_ready` never drops. A run of `NPTS/2` back-to-back butterflies is accepted in `NPTS/2` consecutive cycles and comes out in `NPTS/2` consecutive cycles.
- R7: Multipliers are used in strict rotation. `in_ready` is low while the next multiplier in the rotation is still working. A held input is taken exactly once, at the edge where that multiplier finishes. With `NUNITS = 3` and `NTERMS = 4`, the fourth of a back-to-back burst is accepted 10 cycles after the first.
- R8: Synchronous reset clears all work in flight, restarts the rotation, holds `out_valid` at 0 and leaves `in_ready` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input butterfly present |
| in_ready | output | 1 | Next multiplier in the rotation can take an input |
| in_inverse | input | 1 | 1 selects the inverse transform (conjugate twiddle) |
| in_tw_idx | input | $clog2(NPTS/2) | Twiddle index k |
| in_a_re | input | DW | Sample a, real part, signed |
| in_a_im | input | DW | Sample a, imaginary part, signed |
| in_b_re | input | DW | Sample b, real part, signed |
| in_b_im | input | DW | Sample b, imaginary part, signed |
| out_valid | output | 1 | Output butterfly present |
| out_x_re | output | DW | Upper output (halved sum), real part |
| out_x_im | output | DW | Upper output (halved sum), imaginary part |
| out_y_re | output | DW | Lower output (rotated halved difference), real part |
| out_y_im | output | DW | Lower output (rotated halved difference), imaginary part |

## Verification
The assertions check the following properties on every cycle:
- At most one multiplier finishes per cycle.
- Multipliers finish in the same rotation in which they were started.
- No multiplier is restarted while it is still working.
- The count of butterflies in flight never exceeds the number of multipliers.
- `out_valid` stays low right after reset.

Only the bench scenarios can show the following:
- The arithmetic values: the guard-bit sum, the rotated difference, the rounding of the twiddles to a few one-bits, and the conjugation in the inverse direction.
- The exact latency and full-rate streaming.
- The stall pattern of a small multiplier set.

// File: rtl/bfly_pkg.sv
`timescale 1ns/1ps
package bfly_pkg;

  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_INV = 1'b1
  } dir_e;

  localparam real TWO_PI = 6.283185307179586;

  // bits needed to name any bit position of a Q(twf) magnitude
  function automatic int pos_width(input int twf);
    return $clog2(twf + 1);
  endfunction

  // selector width that stays legal for a count of one
  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bfly_tw_rom.sv
`timescale 1ns/1ps
module bfly_tw_rom #(
  parameter int NPTS   = 1024,
  parameter int TWF    = 30,
  parameter int NTERMS = 4
) (
  input  logic                               clk,
  input  logic                               rd_en,
  input  logic [$clog2(NPTS/2)-1:0]          rd_idx,
  output logic [2*(1+NTERMS+NTERMS*bfly_pkg::pos_width(TWF))-1:0] rd_q
);
  localparam int PW    = bfly_pkg::pos_width(TWF);
  localparam int CW    = 1 + NTERMS + NTERMS * PW;
  localparam int EW    = 2 * CW;
  localparam int DEPTH = NPTS / 2;

  // one component: {negative, term valid[NTERMS-1:0], term position[NTERMS][PW]}
  function automatic logic [CW-1:0] encode(input real v);
    logic [CW-1:0] e;
    int            mag;
    int            used;
    real           av;
    e    = '0;
    av   = (v < 0.0) ? -v : v;
    mag  = $rtoi(av * (2.0 ** TWF) + 0.5);
    used = 0;
    for (int b = TWF; b >= 0; b--) begin
      if (mag[b] && used < NTERMS) begin
        e[used*PW +: PW]     = PW'(b);
        e[NTERMS*PW + used]  = 1'b1;
        used++;
      end
    end
    e[CW-1] = (v < 0.0);
    return e;
  endfunction

  logic [EW-1:0] mem [DEPTH];

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      real ang;
      ang    = bfly_pkg::TWO_PI * real'(k) / real'(NPTS);
      mem[k] = {encode($cos(ang)), encode(-$sin(ang))};
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_idx];
  end

endmodule

// File: rtl/bfly_sa_acc.sv
`timescale 1ns/1ps
module bfly_sa_acc #(
  parameter int OPW = 33,
  parameter int AW  = 68,
  parameter int PW  = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear,
  input  logic                  step,
  input  logic signed [OPW-1:0] op,
  input  logic                  neg,
  input  logic                  use_term,
  input  logic [PW-1:0]         sh,
  output logic signed [AW-1:0]  acc
);
  logic signed [AW-1:0] ext;
  logic signed [AW-1:0] term;

  assign ext  = AW'(op);
  assign term = ext <<< sh;

  always_ff @(posedge clk) begin
    if (rst || clear)          acc <= '0;
    else if (step && use_term) acc <= neg ? (acc - term) : (acc + term);
  end

endmodule

// File: rtl/bfly_cmul_unit.sv
`timescale 1ns/1ps
module bfly_cmul_unit #(
  parameter int DW     = 32,
  parameter int TWF    = 30,
  parameter int NTERMS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 issue,
  input  logic                 inv,
  input  logic signed [DW:0]   d_re,
  input  logic signed [DW:0]   d_im,
  input  logic [DW-1:0]        s_re,
  input  logic [DW-1:0]        s_im,
  input  logic [2*(1+NTERMS+NTERMS*bfly_pkg::pos_width(TWF))-1:0] coef,
  output logic                 busy,
  output logic                 done,
  output logic [DW-1:0]        y_re,
  output logic [DW-1:0]        y_im,
  output logic [DW-1:0]        x_re,
  output logic [DW-1:0]        x_im
);
  import bfly_pkg::*;

  localparam int PW    = pos_width(TWF);
  localparam int CW    = 1 + NTERMS + NTERMS * PW;
  localparam int EW    = 2 * CW;
  localparam int LASTC = 2 * NTERMS + 1;
  localparam int CNTW  = $clog2(LASTC + 1);
  localparam int OPW   = DW + 1;
  localparam int AW    = OPW + TWF + $clog2(2 * NTERMS) + 2;

  logic                   busy_q;
  logic [CNTW-1:0]        cnt;
  logic signed [OPW-1:0]  dr, di;
  logic [DW-1:0]          sr, si;
  dir_e                   dir_q;
  logic [EW-1:0]          coef_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt    <= '0;
    end else if (issue) begin
      busy_q <= 1'b1;
      cnt    <= '0;
      dr     <= d_re;
      di     <= d_im;
      sr     <= s_re;
      si     <= s_im;
      dir_q  <= dir_e'(inv);
    end else if (busy_q) begin
      if (done) busy_q <= 1'b0;
      else      cnt    <= cnt + 1'b1;
      if (cnt == '0)
        coef_q <= {coef[EW-1:CW], coef[CW-1] ^ (dir_q == DIR_INV), coef[CW-2:0]};
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt == CNTW'(LASTC));

  // iteration t = cnt-1 walks the first coefficient for dr, then the other for di
  logic            step;
  logic [CNTW-1:0] t;
  logic            half;
  logic [CNTW-1:0] j;
  logic [CW-1:0]   cr, ci;

  assign step = busy_q && (cnt != '0) && !done;
  assign t    = cnt - 1'b1;
  assign half = (t >= CNTW'(NTERMS));
  assign j    = half ? (t - CNTW'(NTERMS)) : t;
  assign cr   = coef_q[EW-1:CW];
  assign ci   = coef_q[CW-1:0];

  logic signed [AW-1:0] acc [2];

  // lane 0: dr*Wr - di*Wi ; lane 1: dr*Wi + di*Wr
  for (genvar L = 0; L < 2; L++) begin : g_lane
    logic [CW-1:0] c_sel;
    logic          neg;
    logic          use_t;
    logic [PW-1:0] sh;
    assign c_sel = ((L == 0) ^ half) ? cr : ci;
    assign neg   = c_sel[CW-1] ^ ((L == 0) && half);
    assign use_t = c_sel[NTERMS*PW + int'(j)];
    assign sh    = c_sel[int'(j)*PW +: PW];

    bfly_sa_acc #(.OPW(OPW), .AW(AW), .PW(PW)) u_acc (
      .clk      (clk),
      .rst      (rst),
      .clear    (issue),
      .step     (step),
      .op       (half ? di : dr),
      .neg      (neg),
      .use_term (use_t),
      .sh       (sh),
      .acc      (acc[L])
    );
  end

  // product carries TWF fraction bits; one more bit of shift is the stage scaling
  assign y_re = acc[0][TWF+1 +: DW];
  assign y_im = acc[1][TWF+1 +: DW];
  assign x_re = sr;
  assign x_im = si;

  logic unused_acc_bits;
  assign unused_acc_bits = ^{acc[0][TWF:0], acc[1][TWF:0],
                             acc[0][AW-1:TWF+1+DW], acc[1][AW-1:TWF+1+DW]};

  // R7: a unit is restarted only when idle or in its finishing cycle
  a_r7_no_clobber: assert property (@(posedge clk) disable iff (rst)
    issue |-> (!busy_q || done));

  // R5: once finished, the unit drops busy unless restarted in the same edge
  a_r5_release: assert property (@(posedge clk) disable iff (rst)
    (done && !issue) |=> !busy_q);

endmodule

// File: rtl/dif_bfly_r2.sv
`timescale 1ns/1ps
module dif_bfly_r2 #(
  parameter int NPTS   = 1024,
  parameter int DW     = 32,
  parameter int TWF    = 30,
  parameter int NTERMS = 4,
  parameter int NUNITS = 2 * NTERMS + 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic                       in_inverse,
  input  logic [$clog2(NPTS/2)-1:0]  in_tw_idx,
  input  logic signed [DW-1:0]       in_a_re,
  input  logic signed [DW-1:0]       in_a_im,
  input  logic signed [DW-1:0]       in_b_re,
  input  logic signed [DW-1:0]       in_b_im,
  output logic                       out_valid,
  output logic [DW-1:0]              out_x_re,
  output logic [DW-1:0]              out_x_im,
  output logic [DW-1:0]              out_y_re,
  output logic [DW-1:0]              out_y_im
);
  import bfly_pkg::*;

  localparam int PW  = pos_width(TWF);
  localparam int EW  = 2 * (1 + NTERMS + NTERMS * PW);
  localparam int UPW = sel_width(NUNITS);

  // guard-bit sum and difference
  logic signed [DW:0] sum_re, sum_im, dif_re, dif_im;
  assign sum_re = {in_a_re[DW-1], in_a_re} + {in_b_re[DW-1], in_b_re};
  assign sum_im = {in_a_im[DW-1], in_a_im} + {in_b_im[DW-1], in_b_im};
  assign dif_re = {in_a_re[DW-1], in_a_re} - {in_b_re[DW-1], in_b_re};
  assign dif_im = {in_a_im[DW-1], in_a_im} - {in_b_im[DW-1], in_b_im};

  logic unused_sum_lsb;
  assign unused_sum_lsb = sum_re[0] ^ sum_im[0];

  // rotation pointer
  logic [UPW-1:0]    ptr;
  logic [NUNITS-1:0] busy_v, done_v, iss_v;
  logic              issue;

  assign in_ready = !busy_v[ptr] || done_v[ptr];
  assign issue    = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst)        ptr <= '0;
    else if (issue) ptr <= (ptr == UPW'(NUNITS - 1)) ? '0 : ptr + 1'b1;
  end

  logic [EW-1:0] coef;

  bfly_tw_rom #(.NPTS(NPTS), .TWF(TWF), .NTERMS(NTERMS)) u_rom (
    .clk    (clk),
    .rd_en  (issue),
    .rd_idx (in_tw_idx),
    .rd_q   (coef)
  );

  logic [DW-1:0] yr_v [NUNITS];
  logic [DW-1:0] yi_v [NUNITS];
  logic [DW-1:0] xr_v [NUNITS];
  logic [DW-1:0] xi_v [NUNITS];

  for (genvar i = 0; i < NUNITS; i++) begin : g_unit
    assign iss_v[i] = issue && (ptr == UPW'(i));
    bfly_cmul_unit #(.DW(DW), .TWF(TWF), .NTERMS(NTERMS)) u_mul (
      .clk   (clk),
      .rst   (rst),
      .issue (iss_v[i]),
      .inv   (in_inverse),
      .d_re  (dif_re),
      .d_im  (dif_im),
      .s_re  (sum_re[DW:1]),
      .s_im  (sum_im[DW:1]),
      .coef  (coef),
      .busy  (busy_v[i]),
      .done  (done_v[i]),
      .y_re  (yr_v[i]),
      .y_im  (yi_v[i]),
      .x_re  (xr_v[i]),
      .x_im  (xi_v[i])
    );
  end

  // at most one unit finishes per cycle: OR-merge the finishers
  logic          any_done;
  logic [DW-1:0] m_xr, m_xi, m_yr, m_yi;

  always_comb begin
    any_done = 1'b0;
    m_xr = '0; m_xi = '0; m_yr = '0; m_yi = '0;
    for (int i = 0; i < NUNITS; i++) begin
      if (done_v[i]) begin
        any_done = 1'b1;
        m_xr = m_xr | xr_v[i];
        m_xi = m_xi | xi_v[i];
        m_yr = m_yr | yr_v[i];
        m_yi = m_yi | yi_v[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= any_done;
    if (any_done) begin
      out_x_re <= m_xr;
      out_x_im <= m_xi;
      out_y_re <= m_yr;
      out_y_im <= m_yi;
    end
  end

  // checker state: expected finisher and butterflies in flight
  logic [UPW-1:0] chk_dptr;
  logic [UPW:0]   chk_live;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_dptr <= '0;
      chk_live <= '0;
    end else begin
      if (any_done) chk_dptr <= (chk_dptr == UPW'(NUNITS - 1)) ? '0 : chk_dptr + 1'b1;
      chk_live <= chk_live + (UPW+1)'(issue) - (UPW+1)'(any_done);
    end
  end

  a_r5_one_finisher: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done_v));

  a_r5_finish_order: assert property (@(posedge clk) disable iff (rst)
    any_done |-> done_v[chk_dptr]);

  a_r7_live_bound: assert property (@(posedge clk) disable iff (rst)
    chk_live <= (UPW+1)'(NUNITS));

  a_r8_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

endmodule

// File: tb/tb_dif_bfly_r2.sv
`timescale 1ns/1ps
module tb_dif_bfly_r2;
  localparam int NPTS  = 1024;
  localparam int DW    = 32;
  localparam int TWF   = 30;
  localparam int NT    = 4;
  localparam int LAT   = 2 * NT + 2;
  localparam int NU_BP = 3;
  localparam int IW    = $clog2(NPTS / 2);
  localparam int QD    = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic              vin [2];
  logic              ivs [2];
  logic [IW-1:0]     kin [2];
  logic signed [31:0] ar [2], ai [2], br [2], bi [2];
  logic              rdy [2];
  logic              ov  [2];
  logic [31:0]       xr [2], xi [2], yr [2], yi [2];

  dif_bfly_r2 #(.NPTS(NPTS), .DW(DW), .TWF(TWF), .NTERMS(NT)) dut (
    .clk(clk), .rst(rst), .in_valid(vin[0]), .in_ready(rdy[0]), .in_inverse(ivs[0]),
    .in_tw_idx(kin[0]), .in_a_re(ar[0]), .in_a_im(ai[0]), .in_b_re(br[0]), .in_b_im(bi[0]),
    .out_valid(ov[0]), .out_x_re(xr[0]), .out_x_im(xi[0]), .out_y_re(yr[0]), .out_y_im(yi[0]));

  dif_bfly_r2 #(.NPTS(NPTS), .DW(DW), .TWF(TWF), .NTERMS(NT), .NUNITS(NU_BP)) dut_bp (
    .clk(clk), .rst(rst), .in_valid(vin[1]), .in_ready(rdy[1]), .in_inverse(ivs[1]),
    .in_tw_idx(kin[1]), .in_a_re(ar[1]), .in_a_im(ai[1]), .in_b_re(br[1]), .in_b_im(bi[1]),
    .out_valid(ov[1]), .out_x_re(xr[1]), .out_x_im(xi[1]), .out_y_re(yr[1]), .out_y_im(yi[1]));

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // scoreboard per device
  logic [31:0] e_xr [2][QD], e_xi [2][QD], e_yr [2][QD], e_yi [2][QD];
  int          e_cy [2][QD];
  string       e_tg [2][QD];
  int hd [2] = '{0, 0};
  int tl [2] = '{0, 0};
  int stalls [2] = '{0, 0};
  int outs [2] = '{0, 0};

  // twiddle component per R3: round to Q30, keep the top NT one-bits
  function automatic longint approx(input real v);
    longint rem, res;
    real    av;
    int     p;
    av  = (v < 0.0) ? -v : v;
    rem = longint'($rtoi(av * 1073741824.0 + 0.5));
    res = 0;
    for (int n = 0; n < NT; n++) begin
      if (rem == 0) break;
      p = 40;
      while (rem[p] == 1'b0) p--;
      res = res + (longint'(1) <<< p);
      rem = rem - (longint'(1) <<< p);
    end
    return (v < 0.0) ? -res : res;
  endfunction

  task automatic push_exp(input int d, input longint a_r, a_i, b_r, b_i,
                          input int k, input bit iv, input string tag, input int pc);
    longint sr, si, dr, di, wr, wi, pr, pi;
    real    ang;
    ang = 6.283185307179586 * real'(k) / real'(NPTS);
    wr  = approx($cos(ang));
    wi  = approx(-$sin(ang));
    if (iv) wi = -wi;
    sr = (a_r + b_r) >>> 1;
    si = (a_i + b_i) >>> 1;
    dr = a_r - b_r;
    di = a_i - b_i;
    pr = (dr * wr - di * wi) >>> 31;
    pi = (dr * wi + di * wr) >>> 31;
    e_xr[d][tl[d] % QD] = sr[31:0];
    e_xi[d][tl[d] % QD] = si[31:0];
    e_yr[d][tl[d] % QD] = pr[31:0];
    e_yi[d][tl[d] % QD] = pi[31:0];
    e_cy[d][tl[d] % QD] = pc + LAT;
    e_tg[d][tl[d] % QD] = tag;
    tl[d]++;
  endtask

  task automatic send(input int d, input longint a_r, a_i, b_r, b_i,
                      input int k, input bit iv, input string tag, output int pc);
    vin[d] = 1'b1;
    ar[d]  = a_r[31:0];
    ai[d]  = a_i[31:0];
    br[d]  = b_r[31:0];
    bi[d]  = b_i[31:0];
    kin[d] = k[IW-1:0];
    ivs[d] = iv;
    while (!rdy[d]) begin
      stalls[d]++;
      @(negedge clk);
    end
    pc = cyc + 1;
    push_exp(d, a_r, a_i, b_r, b_i, k, iv, tag, pc);
    @(negedge clk);
  endtask

  task automatic idle(input int d);
    vin[d] = 1'b0;
  endtask

  task automatic drain(input int d, input string req);
    int w;
    w = 0;
    while (hd[d] != tl[d] && w < 4000) begin
      @(negedge clk);
      w++;
    end
    chk(hd[d] == tl[d], req, "outputs drained", hd[d], tl[d]);
  endtask

  // output monitor: values (R1, R2/R3/R4) and latency/order (R5)
  always @(negedge clk) begin
    if (!rst) begin
      for (int d = 0; d < 2; d++) begin
        if (ov[d]) begin
          outs[d]++;
          if (hd[d] == tl[d]) begin
            chk(1'b0, "R5", "unexpected output", 1, 0);
          end else begin
            int s;
            s = hd[d] % QD;
            chk(xr[d] == e_xr[d][s], "R1", "x real", longint'($signed(xr[d])), longint'($signed(e_xr[d][s])));
            chk(xi[d] == e_xi[d][s], "R1", "x imag", longint'($signed(xi[d])), longint'($signed(e_xi[d][s])));
            chk(yr[d] == e_yr[d][s], e_tg[d][s], "y real", longint'($signed(yr[d])), longint'($signed(e_yr[d][s])));
            chk(yi[d] == e_yi[d][s], e_tg[d][s], "y imag", longint'($signed(yi[d])), longint'($signed(e_yi[d][s])));
            chk(cyc == e_cy[d][s], "R5", "output cycle", cyc, e_cy[d][s]);
            hd[d]++;
          end
        end
      end
    end
  end

  task automatic do_reset();
    vin[0] = 1'b0;
    vin[1] = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    hd = '{0, 0};
    tl = '{0, 0};
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    for (int d = 0; d < 2; d++) begin
      chk(ov[d] == 1'b0, "R8", "out_valid after reset", ov[d], 0);
      chk(rdy[d] == 1'b1, "R8", "in_ready after reset", rdy[d], 1);
    end
  endtask

  task automatic t_sum_guard();
    int pc;
    send(0, 64'sd2147483647, -64'sd2147483648, 64'sd2147483647, -64'sd2147483648, 0, 1'b0, "R1", pc);
    send(0, -64'sd2147483648, 64'sd2147483647, 64'sd2147483647, -64'sd2147483648, 0, 1'b0, "R1", pc);
    send(0, 64'sd2147483647, 64'sd1, -64'sd2147483648, -64'sd3, 0, 1'b1, "R1", pc);
    send(0, -64'sd5, 64'sd7, 64'sd2, -64'sd2, 0, 1'b0, "R1", pc);
    idle(0);
    drain(0, "R1");
  endtask

  task automatic t_twiddles(input bit iv, input string tag);
    int ks [7] = '{0, 128, 256, 384, 64, 511, 300};
    int pc;
    foreach (ks[n]) begin
      send(0, 64'sd30000000 + n * 1234567, -64'sd20000000, -64'sd11000000,
           64'sd4000000 - n * 777777, ks[n], iv, tag, pc);
    end
    idle(0);
    drain(0, tag);
  endtask

  task automatic t_stream();
    int pc, first, last, st0, o0;
    st0 = stalls[0];
    o0  = outs[0];
    for (int i = 0; i < NPTS / 2; i++) begin
      longint va, vb;
      va = longint'((i * 37) % 4096 - 2048) <<< 14;
      vb = longint'((i * 91) % 2048 - 1024) <<< 15;
      send(0, va, vb, -vb, va + 5, i, i[0], "R2", pc);
      if (i == 0) first = pc;
      last = pc;
    end
    idle(0);
    chk(stalls[0] == st0, "R6", "stall cycles in stream", stalls[0] - st0, 0);
    chk(last - first == NPTS / 2 - 1, "R6", "accept span", last - first, NPTS / 2 - 1);
    drain(0, "R6");
    chk(outs[0] - o0 == NPTS / 2, "R6", "outputs from stream", outs[0] - o0, NPTS / 2);
  endtask

  task automatic t_backpressure();
    int pc [6];
    int st0;
    st0 = stalls[1];
    for (int i = 0; i < 6; i++)
      send(1, 64'sd1000000 * (i + 1), -64'sd300000, 64'sd250000, 64'sd4000000, 32 * i, 1'b0, "R7", pc[i]);
    idle(1);
    chk(pc[1] - pc[0] == 1, "R7", "second accept gap", pc[1] - pc[0], 1);
    chk(pc[2] - pc[0] == 2, "R7", "third accept gap", pc[2] - pc[0], 2);
    chk(pc[3] - pc[0] == LAT, "R7", "fourth waits for unit 0", pc[3] - pc[0], LAT);
    chk(pc[5] - pc[3] == 2, "R7", "burst after stall", pc[5] - pc[3], 2);
    chk(stalls[1] - st0 == LAT - NU_BP, "R7", "cycles with ready low", stalls[1] - st0, LAT - NU_BP);
    drain(1, "R7");
  endtask

  task automatic t_reset_flush();
    int pc, o0;
    send(0, 64'sd111, 64'sd222, 64'sd333, 64'sd444, 5, 1'b0, "R8", pc);
    send(0, 64'sd555, 64'sd666, 64'sd777, 64'sd888, 6, 1'b0, "R8", pc);
    send(1, 64'sd999, 64'sd1, 64'sd2, 64'sd3, 7, 1'b1, "R8", pc);
    do_reset();
    o0 = outs[0] + outs[1];
    repeat (LAT + 4) @(negedge clk);
    chk(outs[0] + outs[1] == o0, "R8", "outputs after flush", outs[0] + outs[1] - o0, 0);
    chk(rdy[0] && rdy[1], "R8", "ready after flush", rdy[0] && rdy[1], 1);
    send(1, 64'sd12345, -64'sd678, 64'sd9, 64'sd10, 200, 1'b0, "R8", pc);
    idle(1);
    drain(1, "R8");
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL R5 watchdog expired: actual %0d cycles expected fewer", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      vin[d] = 1'b0; ivs[d] = 1'b0; kin[d] = '0;
      ar[d] = '0; ai[d] = '0; br[d] = '0; bi[d] = '0;
    end
    @(negedge clk);
    do_reset();
    t_reset_state();
    t_sum_guard();
    t_twiddles(1'b0, "R3");
    t_twiddles(1'b1, "R4");
    t_stream();
    t_backpressure();
    t_reset_flush();
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule